// File: doc/BRIEF.md
# Plus-Selection Evolutionary Search Controller

This block searches for an n-bit vector that minimises a loss computed outside it. It keeps a small population of parent vectors and, in every generation, breeds a fixed number of offspring. Each offspring takes every bit from one of two randomly chosen parents (uniform crossover). It then flips each bit with a probability set at run time. The block hands every new vector to an external loss evaluator over a start/done handshake. When a generation is complete, the next parent set is the lowest-loss part of the union of the old parents and the new offspring.

All random choices come from a 32-bit LFSR that is loaded from a seed input when a run starts. The initial parents are random vectors. The parents are held in a list sorted by loss, so the best vector and its loss are available at all times at the head of that list. After the configured number of generations the block raises `done` and holds the result until the next run.

Top module: `evo_search`

## Requirements
- R1: During and right after synchronous reset, `busy`, `done` and `eval_start` are 0.
- R2: `start` loads the LFSR with `seed`, and a zero seed is replaced by 1. The same seed therefore yields the same first candidate, and seed 0 behaves like seed 1.
- R3: A run evaluates exactly MU initial random vectors, then LAMBDA offspring per generation for `gen_budget` generations. It then enters the finished state with `done`=1.
- R4: `eval_start` is a one-cycle pulse with `eval_vec` valid. No new pulse is issued until `eval_done` has been seen, and `eval_done` is only accepted in a cycle after the pulse.
- R5: With `mut_rate`=0, every offspring bit equals the same bit of at least one current parent.
- R6: Each offspring bit is inverted when an 8-bit random draw is below `mut_rate`. With `mut_rate`=255, offspring leave the bit range spanned by the parents.
- R7: After a generation, the parents are the MU lowest-loss entries of the union, in signed loss order. Ties rank old parents first, then offspring in evaluation order. The same rule applies while the initial vectors are inserted one by one. `best_loss` reads the maximum positive value while the list is empty.
- R8: Within a run, `best_loss` never increases, and `best_vec` changes only when `best_loss` strictly drops.
- R9: While finished, `done`, `best_vec` and `best_loss` stay constant and no evaluation is requested, until a new `start`.
- R10: With `gen_budget`=0, the run finishes right after the MU initial evaluations.
- R11: A `start` pulse during a run is ignored, and the run completes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only when idle or finished |
| seed | input | 32 | LFSR seed captured at start |
| mut_rate | input | 8 | Per-bit flip threshold, captured at start |
| gen_budget | input | GEN_W | Number of generations, captured at start |
| eval_start | output | 1 | One-cycle request to evaluate `eval_vec` |
| eval_vec | output | EVO_N | Candidate under evaluation |
| eval_done | input | 1 | Evaluator result valid |
| eval_loss | input | EVO_LW | Signed loss of the candidate |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result held |
| best_vec | output | EVO_N | Lowest-loss vector kept so far |
| best_loss | output | EVO_LW | Signed loss of `best_vec` |

## Verification
A bad parent list or a wrong merge order shows at the ports from the next evaluation request. Before each request, `best_loss` and `best_vec` are compared with a behavioural sorted-list model that is fed from the same evaluator responses. A mis-drawn crossover bit with mutation off shows up at once as an offspring bit that no parent holds. A wrong budget count or handshake slip changes the number of requests that are seen before `done`, which is checked at the end of each run.

// File: rtl/evo_pkg.sv
package evo_pkg;
    parameter int EVO_N  = 16;   // candidate width in bits
    parameter int EVO_LW = 16;   // signed loss width

    localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

    typedef struct packed {
        logic                     valid;
        logic [EVO_N-1:0]         vec;
        logic signed [EVO_LW-1:0] loss;
    } cand_t;

    typedef enum logic [2:0] {
        S_IDLE, S_INIT, S_PICK, S_BREED, S_REQ, S_WAIT, S_MERGE, S_DONE
    } phase_t;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

    function automatic cand_t empty_cand();
        cand_t c;
        c.valid = 1'b0;
        c.vec   = '0;
        c.loss  = {1'b0, {(EVO_LW-1){1'b1}}};
        return c;
    endfunction
endpackage

// File: rtl/evo_rng.sv
module evo_rng
    import evo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] seed,
    input  logic        adv,
    output logic [31:0] state
);
    always_ff @(posedge clk) begin
        if (rst)       state <= 32'd1;
        else if (load) state <= (seed == 32'd0) ? 32'd1 : seed;
        else if (adv)  state <= lfsr_next(state);
    end

    // R2: a zero state would lock the generator
    p_rng_live_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> state != 32'd0);
endmodule

// File: rtl/evo_pool.sv
module evo_pool
    import evo_pkg::*;
#(
    parameter int MU = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  ins_en,
    input  cand_t ins,
    output cand_t ents [MU]
);
    localparam int POS_W = $clog2(MU + 1);

    // entries are sorted, so the count of ranks not worse than ins is a prefix
    logic [POS_W-1:0] pos;
    always_comb begin
        pos = '0;
        for (int i = 0; i < MU; i++)
            if (ents[i].valid && ents[i].loss <= ins.loss)
                pos = POS_W'(i + 1);
    end

    for (genvar g = 0; g < MU; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear)
                ents[g] <= empty_cand();
            else if (ins_en && pos <= POS_W'(g)) begin
                if (pos == POS_W'(g)) ents[g] <= ins;
                else                  ents[g] <= ents[(g > 0) ? g - 1 : 0];
            end
        end
        if (g < MU - 1) begin : g_ord
            p_sorted_r7: assert property (@(posedge clk) disable iff (rst)
                ents[g+1].valid |-> ents[g].valid && ents[g].loss <= ents[g+1].loss);
        end
    end

    p_best_mono_r8: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ents[0].loss <= $past(ents[0].loss));
    p_tie_keep_r8: assert property (@(posedge clk) disable iff (rst)
        !clear && ents[0].valid |=> (ents[0].loss != $past(ents[0].loss)) || $stable(ents[0].vec));
endmodule

// File: rtl/evo_search.sv
module evo_search
    import evo_pkg::*;
#(
    parameter int MU     = 4,
    parameter int LAMBDA = 4,
    parameter int GEN_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [31:0]              seed,
    input  logic [7:0]               mut_rate,
    input  logic [GEN_W-1:0]         gen_budget,
    output logic                     eval_start,
    output logic [EVO_N-1:0]         eval_vec,
    input  logic                     eval_done,
    input  logic signed [EVO_LW-1:0] eval_loss,
    output logic                     busy,
    output logic                     done,
    output logic [EVO_N-1:0]         best_vec,
    output logic signed [EVO_LW-1:0] best_loss
);
    localparam int PIDX_W  = (MU > 1) ? $clog2(MU) : 1;
    localparam int KIDX_W  = (LAMBDA > 1) ? $clog2(LAMBDA) : 1;
    localparam int BIT_W   = (EVO_N > 1) ? $clog2(EVO_N) : 1;
    localparam int CNT_MAX = (MU > LAMBDA) ? MU : LAMBDA;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;

    phase_t             st;
    logic               seeding;
    logic [EVO_N-1:0]   work;
    logic [BIT_W-1:0]   bit_idx;
    logic [PIDX_W-1:0]  pa, pb;
    logic [CNT_W-1:0]   cnt;
    logic [GEN_W-1:0]   gen_left;
    logic [7:0]         mut_q;
    cand_t              kids [LAMBDA];
    cand_t              ents [MU];
    logic [31:0]        rnd;
    logic               launch, rng_adv, last_bit, xbit, bred, ins_en;
    cand_t              ins_c;

    assign launch   = (st == S_IDLE || st == S_DONE) && start;
    assign rng_adv  = (st == S_INIT) || (st == S_PICK) || (st == S_BREED);
    assign last_bit = (bit_idx == BIT_W'(EVO_N - 1));

    evo_rng u_rng (
        .clk(clk), .rst(rst), .load(launch), .seed(seed), .adv(rng_adv), .state(rnd)
    );

    // uniform crossover bit, then mutation against the latched threshold
    always_comb begin
        xbit = rnd[0] ? ents[pa].vec[bit_idx] : ents[pb].vec[bit_idx];
        bred = xbit ^ (rnd[15:8] < mut_q);
    end

    always_comb begin
        ins_en = 1'b0;
        ins_c  = '{valid: 1'b1, vec: work, loss: eval_loss};
        if (st == S_WAIT && eval_done && seeding) ins_en = 1'b1;
        if (st == S_MERGE) begin
            ins_en = 1'b1;
            ins_c  = kids[KIDX_W'(cnt)];
        end
    end

    evo_pool #(.MU(MU)) u_pool (
        .clk(clk), .rst(rst), .clear(launch), .ins_en(ins_en), .ins(ins_c), .ents(ents)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            seeding  <= 1'b0;
            work     <= '0;
            bit_idx  <= '0;
            pa       <= '0;
            pb       <= '0;
            cnt      <= '0;
            gen_left <= '0;
            mut_q    <= '0;
            for (int k = 0; k < LAMBDA; k++) kids[k] <= empty_cand();
        end else begin
            case (st)
                S_IDLE, S_DONE: if (start) begin
                    st       <= S_INIT;
                    seeding  <= 1'b1;
                    bit_idx  <= '0;
                    cnt      <= '0;
                    gen_left <= gen_budget;
                    mut_q    <= mut_rate;
                end
                S_INIT: begin
                    work[bit_idx] <= rnd[0];
                    bit_idx       <= bit_idx + 1'b1;
                    if (last_bit) st <= S_REQ;
                end
                S_PICK: begin
                    pa      <= PIDX_W'(int'(rnd[7:0]) % MU);
                    pb      <= PIDX_W'(int'(rnd[23:16]) % MU);
                    bit_idx <= '0;
                    st      <= S_BREED;
                end
                S_BREED: begin
                    work[bit_idx] <= bred;
                    bit_idx       <= bit_idx + 1'b1;
                    if (last_bit) st <= S_REQ;
                end
                S_REQ: st <= S_WAIT;
                S_WAIT: if (eval_done) begin
                    bit_idx <= '0;
                    if (seeding) begin
                        if (cnt == CNT_W'(MU - 1)) begin
                            cnt     <= '0;
                            seeding <= 1'b0;
                            st      <= (gen_left == '0) ? S_DONE : S_PICK;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= S_INIT;
                        end
                    end else begin
                        kids[KIDX_W'(cnt)] <= '{valid: 1'b1, vec: work, loss: eval_loss};
                        if (cnt == CNT_W'(LAMBDA - 1)) begin
                            cnt <= '0;
                            st  <= S_MERGE;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= S_PICK;
                        end
                    end
                end
                S_MERGE: begin
                    if (cnt == CNT_W'(LAMBDA - 1)) begin
                        cnt      <= '0;
                        gen_left <= gen_left - 1'b1;
                        st       <= (gen_left == GEN_W'(1)) ? S_DONE : S_PICK;
                    end else
                        cnt <= cnt + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign eval_start = (st == S_REQ);
    assign eval_vec   = work;
    assign busy       = (st != S_IDLE) && (st != S_DONE);
    assign done       = (st == S_DONE);
    assign best_vec   = ents[0].vec;
    assign best_loss  = ents[0].loss;

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        eval_start |=> !eval_start);
    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(best_vec) && $stable(best_loss));
    p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !eval_start && !busy);
endmodule

// File: tb/evo_search_test.sv
module evo_search_test;
    import evo_pkg::*;
    localparam int CLK_NS = 10;
    localparam int MU = 4;
    localparam int LAMBDA = 4;
    localparam int LMAX = 32767;

    logic clk = 0, rst = 1, start = 0, eval_done = 0;
    logic [31:0] seed = 0;
    logic [7:0] mut_rate = 0;
    logic [15:0] gen_budget = 0;
    logic signed [15:0] eval_loss = 0;
    logic eval_start, busy, done;
    logic [15:0] eval_vec, best_vec;
    logic signed [15:0] best_loss;

    evo_search #(.MU(MU), .LAMBDA(LAMBDA), .GEN_W(16)) uut (
        .clk(clk), .rst(rst), .start(start), .seed(seed), .mut_rate(mut_rate),
        .gen_budget(gen_budget), .eval_start(eval_start), .eval_vec(eval_vec),
        .eval_done(eval_done), .eval_loss(eval_loss), .busy(busy), .done(done),
        .best_vec(best_vec), .best_loss(best_loss));

    always #(CLK_NS/2) clk = ~clk;

    int total = 0, bad = 0;
    int m_loss[$]; logic [15:0] m_vec[$];
    int k_loss[$]; logic [15:0] k_vec[$];
    int evals = 0, viol = 0, prev_best = 0;
    bit mon_on = 0, pend = 0;
    int dly = 0, cur_loss = 0;
    logic [15:0] cur_vec = 0, first_vec = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lossf(logic [15:0] v);
        return 3*$countones(v & 16'h0F0F) - 2*$countones(v & 16'hF0F0)
             + 4*int'(v[0] & v[15]) - 5*int'(v[3] & v[12]);
    endfunction

    // stable sorted insertion: after every entry whose loss is not larger
    task automatic m_insert(logic [15:0] v, int l);
        int p = 0;
        while (p < m_loss.size() && m_loss[p] <= l) p++;
        if (p < MU) begin
            m_loss.insert(p, l); m_vec.insert(p, v);
            if (m_loss.size() > MU) begin m_loss.delete(MU); m_vec.delete(MU); end
        end
    endtask

    // evaluator and per-clock reference comparison
    initial begin
        forever begin
            @(negedge clk);
            eval_done = 0;
            if (busy) begin
                chk(!mon_on || int'(best_loss) <= prev_best, "R8", "best_loss rose", int'(best_loss), prev_best);
                prev_best = int'(best_loss);
                mon_on = 1;
            end
            if (pend) begin
                if (eval_start) chk(0, "R4", "request while pending", 1, 0);
                dly--;
                if (dly == 0) begin
                    eval_done = 1; eval_loss = 16'(cur_loss); pend = 0;
                    evals++;
                    if (evals <= MU) m_insert(cur_vec, cur_loss);
                    else begin
                        k_vec.push_back(cur_vec); k_loss.push_back(cur_loss);
                        if (k_loss.size() == LAMBDA) begin
                            for (int i = 0; i < LAMBDA; i++) m_insert(k_vec[i], k_loss[i]);
                            k_vec.delete(); k_loss.delete();
                        end
                    end
                end
            end else if (eval_start) begin
                logic [15:0] lo, hi;
                chk(int'(best_loss) == (m_loss.size() > 0 ? m_loss[0] : LMAX), "R7", "best_loss at request",
                    int'(best_loss), m_loss.size() > 0 ? m_loss[0] : LMAX);
                if (m_loss.size() > 0)
                    chk(best_vec == m_vec[0], "R7", "best_vec at request", int'(best_vec), int'(m_vec[0]));
                if (evals == 0) first_vec = eval_vec;
                if (evals >= MU) begin
                    lo = 16'hFFFF; hi = 16'h0000;
                    for (int i = 0; i < m_vec.size(); i++) begin lo &= m_vec[i]; hi |= m_vec[i]; end
                    if (((eval_vec & ~hi) | (~eval_vec & lo)) != 16'h0) viol++;
                end
                cur_vec = eval_vec; cur_loss = lossf(eval_vec);
                dly = 1 + (evals % 3); pend = 1;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic launch(int s, int m, int b);
        m_loss.delete(); m_vec.delete(); k_loss.delete(); k_vec.delete();
        evals = 0; viol = 0; mon_on = 0;
        seed = 32'(s); mut_rate = 8'(m); gen_budget = 16'(b);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic finish_run(string req, int b);
        int n = 0;
        logic [15:0] hv; int hl;
        while (!done && n < 60000) begin @(negedge clk); n++; end
        chk(done, req, "done raised", int'(done), 1);
        chk(evals == MU + LAMBDA*b, "R3", "evaluation count", evals, MU + LAMBDA*b);
        chk(m_loss.size() > 0 && int'(best_loss) == m_loss[0], "R7", "final best_loss",
            int'(best_loss), m_loss.size() > 0 ? m_loss[0] : LMAX);
        chk(m_vec.size() > 0 && best_vec == m_vec[0], "R7", "final best_vec",
            int'(best_vec), m_vec.size() > 0 ? int'(m_vec[0]) : 0);
        hv = best_vec; hl = int'(best_loss);
        repeat (6) begin
            @(negedge clk);
            chk(done && !eval_start && best_vec == hv && int'(best_loss) == hl, "R9", "result held",
                int'(best_vec), int'(hv));
        end
    endtask

    initial begin
        logic [15:0] fv_a, fv_c;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !eval_start, "R1", "outputs in reset", int'({busy, done, eval_start}), 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !eval_start, "R1", "outputs after reset", int'({busy, done, eval_start}), 0);

        // run A: no mutation, offspring stay inside parent bounds
        launch(32'h0000_1234, 0, 10);
        finish_run("R3", 10);
        chk(viol == 0, "R5", "crossover bits outside parents", viol, 0);
        fv_a = first_vec;

        // run B: same seed, full mutation
        launch(32'h0000_1234, 255, 20);
        finish_run("R3", 20);
        chk(viol > 0, "R6", "mutated offspring outside parents", viol, 1);
        chk(first_vec == fv_a, "R2", "same seed same first vector", int'(first_vec), int'(fv_a));

        // run C: zero seed, zero budget
        launch(0, 30, 0);
        finish_run("R10", 0);
        fv_c = first_vec;

        // run E: seed one must match the zero-seed run
        launch(1, 30, 0);
        finish_run("R10", 0);
        chk(first_vec == fv_c, "R2", "zero seed acts as one", int'(first_vec), int'(fv_c));

        // run D: start during a run is ignored
        launch(32'hC0FF_EE01, 20, 6);
        repeat (80) @(negedge clk);
        seed = 32'h5555_AAAA; gen_budget = 16'd1;
        start = 1; @(negedge clk); start = 0;
        chk(busy, "R11", "still busy after start pulse", int'(busy), 1);
        finish_run("R11", 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule